// File: doc/BRIEF.md
# Seconds counter real-time clock with match interrupt

This block keeps wall-clock time as a 32-bit count of seconds. A prescaler divides the system clock by `CLK_HZ` and produces a one-cycle tick. Each tick advances the count by one, and the count wraps from all ones back to zero. Software sets the time by writing a load value. The new value takes effect at once, and the prescaler restarts so that the first full second begins at that write.

A compare value can be programmed. When the count becomes equal to it, a sticky raw status bit is set. This happens when a tick lands on the compare value, and also at once when a write to the compare or load register makes the two equal. The raw bit is gated by a one-bit mask to drive a level-sensitive interrupt line, and software clears it through a write-only clear register.

The block sits on a zero-wait-state APB-style bus with a 4 KB window. Read data is registered. Eight fixed identification bytes occupy the top eight words of the window.

Top module: `sec_rtc`

## Requirements
- R1: After a synchronous reset, the count, compare, load, mask and raw status registers are zero and `irq` is low.
- R2: The count advances by one exactly `CLK_HZ` clocks after the clock edge that accepts a load write, so a load write restarts the prescaler.
- R3: On a tick, a count of 0xFFFFFFFF becomes 0.
- R4: A write to word 0x08 takes effect at once. The count takes the written value, and reads of 0x08 return the value last written. Reads of 0x00 return the current count.
- R5: When a tick makes the count equal to the compare value (word 0x04), raw status bit 0 (word 0x14) is set.
- R6: A write to the compare or load register that leaves the count equal to the compare value sets raw status bit 0 in the same cycle, without waiting for a tick.
- R7: The mask register (word 0x10) keeps only bit 0 of a write. Masked status (word 0x18) reads raw AND mask, and `irq` equals that masked bit.
- R8: A write to word 0x1C clears raw status bit 0 when bit 0 of the data is one, and otherwise leaves it unchanged. The bit is not set again while the count merely stays equal to the compare value.
- R9: The control word 0x0C always reads 1, and writes to it change nothing.
- R10: Words 0xFE0 through 0xFFC read, in ascending address order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R11: Reads of word 0x1C and of unmapped words return 0. Writes to words 0x00, 0x14, 0x18 and to unmapped words change nothing.
- R12: Read data is captured at the setup-phase clock edge and held through the access phase. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high, read when low |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
The hardest case to reach is a compare event that no tick caused. It arises when a write to the compare or load register makes the count equal to the compare value. A closely related case is a clear that arrives while the count still equals the compare value.

The bench reaches both by loading a known count and then writing the same value to the compare register, all within a few cycles, well inside one prescaler period. Because no tick can intervene, the immediate set and the absence of a re-set after the clear are both observed cleanly at the ports. Prescaler timing is pinned by reading the count exactly `CLK_HZ`-1 and `CLK_HZ` idle cycles after a load.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;
  localparam int WIDX_W = ADDR_W - 2;

  localparam logic [WIDX_W-1:0] IDX_DATA  = 10'h000;
  localparam logic [WIDX_W-1:0] IDX_CMP   = 10'h001;
  localparam logic [WIDX_W-1:0] IDX_LOAD  = 10'h002;
  localparam logic [WIDX_W-1:0] IDX_CTRL  = 10'h003;
  localparam logic [WIDX_W-1:0] IDX_MASK  = 10'h004;
  localparam logic [WIDX_W-1:0] IDX_RAW   = 10'h005;
  localparam logic [WIDX_W-1:0] IDX_MSK   = 10'h006;
  localparam logic [WIDX_W-1:0] IDX_CLR   = 10'h007;
  localparam logic [WIDX_W-1:0] IDX_IDBASE = 10'h3F8;

  typedef struct packed {
    logic loadWr;
    logic cmpWr;
    logic maskWr;
    logic clearWr;
  } rtcStrobes_t;

  function automatic logic [7:0] idByte(input logic [2:0] sel);
    case (sel)
      3'd0: idByte = 8'h31;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;

  generate
    if (CLK_HZ <= 1) begin : gSingle
      assign tick = 1'b1;
    end else begin : gDiv
      localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);
      logic [PW-1:0] preCnt;
      assign tick = (preCnt == LAST);
      always_ff @(posedge clk) begin
        if (rst || restart) preCnt <= '0;
        else if (tick)      preCnt <= '0;
        else                preCnt <= preCnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sec_rtc_ctrl.sv
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] cmpVal,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              maskBit,
  input  logic              rawStat,
  output rtcStrobes_t       strobes,
  output logic [BUS_W-1:0]  prdata
);
  logic wrAccess;
  logic rdSetup;
  logic [BUS_W-1:0] rdMux;

  assign wrAccess = psel & penable & pwrite;
  assign rdSetup  = psel & ~penable & ~pwrite;

  always_comb begin
    strobes.loadWr  = wrAccess && (wordIdx == IDX_LOAD);
    strobes.cmpWr   = wrAccess && (wordIdx == IDX_CMP);
    strobes.maskWr  = wrAccess && (wordIdx == IDX_MASK);
    strobes.clearWr = wrAccess && (wordIdx == IDX_CLR);
  end

  always_comb begin
    rdMux = '0;
    if (wordIdx >= IDX_IDBASE) begin
      rdMux = {{(BUS_W-8){1'b0}}, idByte(wordIdx[2:0])};
    end else begin
      case (wordIdx)
        IDX_DATA: rdMux = BUS_W'(count);
        IDX_CMP:  rdMux = BUS_W'(cmpVal);
        IDX_LOAD: rdMux = BUS_W'(loadVal);
        IDX_CTRL: rdMux = BUS_W'(1);
        IDX_MASK: rdMux = {{(BUS_W-1){1'b0}}, maskBit};
        IDX_RAW:  rdMux = {{(BUS_W-1){1'b0}}, rawStat};
        IDX_MSK:  rdMux = {{(BUS_W-1){1'b0}}, rawStat & maskBit};
        default:  rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          prdata <= '0;
    else if (rdSetup) prdata <= rdMux;
  end
endmodule

// File: rtl/sec_rtc_dp.sv
module sec_rtc_dp
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  rtcStrobes_t       strobes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] cmpVal,
  output logic [DATA_W-1:0] loadVal,
  output logic              maskBit,
  output logic              rawStat,
  output logic              tick,
  output logic              irq
);
  logic [DATA_W-1:0] nextCount;
  logic [DATA_W-1:0] nextCmp;
  logic              setRaw;
  logic              clrRaw;

  sec_rtc_prescale #(.CLK_HZ(CLK_HZ)) uPre (
    .clk     (clk),
    .rst     (rst),
    .restart (strobes.loadWr),
    .tick    (tick)
  );

  always_comb begin
    if (strobes.loadWr) nextCount = wdata;
    else if (tick)      nextCount = count + 1'b1;
    else                nextCount = count;
    nextCmp = strobes.cmpWr ? wdata : cmpVal;
    setRaw  = (strobes.loadWr | strobes.cmpWr | tick) && (nextCount == nextCmp);
    clrRaw  = strobes.clearWr & wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      cmpVal  <= '0;
      loadVal <= '0;
      maskBit <= 1'b0;
      rawStat <= 1'b0;
    end else begin
      count  <= nextCount;
      cmpVal <= nextCmp;
      if (strobes.loadWr) loadVal <= wdata;
      if (strobes.maskWr) maskBit <= wdata[0];
      rawStat <= setRaw | (rawStat & ~clrRaw);
    end
  end

  assign irq = rawStat & maskBit;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              irq
);
  rtcStrobes_t       strobes;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] cmpVal;
  logic [DATA_W-1:0] loadVal;
  logic              maskBit;
  logic              rawStat;
  logic              tick;

  sec_rtc_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .wordIdx (paddr[ADDR_W-1:2]),
    .count   (count),
    .cmpVal  (cmpVal),
    .loadVal (loadVal),
    .maskBit (maskBit),
    .rawStat (rawStat),
    .strobes (strobes),
    .prdata  (prdata)
  );

  sec_rtc_dp #(.DATA_W(DATA_W), .CLK_HZ(CLK_HZ)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wdata   (DATA_W'(pwdata)),
    .count   (count),
    .cmpVal  (cmpVal),
    .loadVal (loadVal),
    .maskBit (maskBit),
    .rawStat (rawStat),
    .tick    (tick),
    .irq     (irq)
  );
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [BUS_W-1:0]  pwdata,
  input logic [BUS_W-1:0]  prdata,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] cmpVal,
  input logic              maskBit,
  input logic              rawStat,
  input logic              tick
);
  logic busWr;
  logic busRdSetup;
  assign busWr      = psel && penable && pwrite;
  assign busRdSetup = psel && !penable && !pwrite;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq && count == '0 && !rawStat)); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '1 && !(busWr && paddr[11:2] == IDX_LOAD)) |=> (count == '0)); // R3

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (busWr && paddr[11:2] == IDX_LOAD) |=> (count == DATA_W'($past(pwdata)))); // R4

  AST_RAW_ON_EQUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(rawStat) |-> (count == cmpVal)); // R5

  AST_MASK_BIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (busWr && paddr[11:2] == IDX_MASK) |=> (maskBit == $past(pwdata[0]))); // R7

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq |-> (maskBit && rawStat)); // R7

  AST_CTRL_ONE: assert property (@(posedge clk) disable iff (rst)
    (busRdSetup && paddr[11:2] == IDX_CTRL) |=> (prdata == BUS_W'(1))); // R9
endmodule

bind sec_rtc sec_rtc_chk #(.DATA_W(DATA_W)) chk (.*);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
  localparam int H = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int total = 0;
  int failed = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  sec_rtc #(.DATA_W(32), .CLK_HZ(H)) uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  task automatic finishRun();
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  // Driver: pushes the expected word, the monitor compares it.
  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  // Monitor: detects an access-phase read, compares at the following negedge.
  always @(posedge clk) begin
    if (psel && penable && !pwrite) begin
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(prdata, 32'hx, "unexpected read");
      end else begin
        check(prdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({31'd0, irq}, 0, "R1 irq low after reset");
    busRead(12'h000, 0, "R1 count zero");
    busRead(12'h004, 0, "R1 compare zero");
    busRead(12'h008, 0, "R1 load zero");
    busRead(12'h010, 0, "R1 mask zero");
    busRead(12'h014, 0, "R1 raw zero");

    busRead(12'h00C, 1, "R9 control reads one");
    busWrite(12'h00C, 0);
    busRead(12'h00C, 1, "R9 control unchanged by write");

    begin
      logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++) busRead(12'hFE0 + 12'(4*i), {24'd0, ids[i]}, "R10 id byte");
    end

    busRead(12'h01C, 0, "R11 clear reads zero");
    busRead(12'h020, 0, "R11 unmapped reads zero");
    busRead(12'h800, 0, "R11 unmapped reads zero");

    busWrite(12'h008, 32'h1234_0000);
    busRead(12'h000, 32'h1234_0000, "R4 count takes load");
    busRead(12'h008, 32'h1234_0000, "R4 load readback");

    busWrite(12'h004, 32'h0000_ABCD);
    busRead(12'h006, 32'h0000_ABCD, "R12 low address bits ignored");

    busWrite(12'h008, 32'h50);
    busWrite(12'h000, 32'hDEAD);
    busWrite(12'h014, 32'h1);
    busWrite(12'h018, 32'h1);
    busWrite(12'h020, 32'h77);
    busRead(12'h000, 32'h50, "R11 write to data ignored");
    busRead(12'h014, 0, "R11 write to raw ignored");
    busRead(12'h004, 32'h0000_ABCD, "R11 unmapped write ignored");

    busWrite(12'h008, 32'h100);
    repeat (H-1) @(negedge clk);
    busRead(12'h000, 32'h100, "R2 no advance before period");
    busWrite(12'h008, 32'h200);
    repeat (H) @(negedge clk);
    busRead(12'h000, 32'h201, "R2 advance after period");

    busWrite(12'h008, 32'hFFFF_FFFF);
    repeat (H) @(negedge clk);
    busRead(12'h000, 0, "R3 wrap to zero");

    busWrite(12'h010, 32'hFFFF_FFFE);
    busRead(12'h010, 0, "R7 mask keeps bit0 only");
    busWrite(12'h010, 32'h3);
    busRead(12'h010, 1, "R7 mask bit0 set");

    busWrite(12'h010, 0);
    busWrite(12'h008, 32'h700);
    busWrite(12'h004, 32'h700);
    busRead(12'h014, 1, "R6 compare write sets raw");
    busRead(12'h018, 0, "R7 masked status gated");
    check({31'd0, irq}, 0, "R7 irq gated by mask");
    busWrite(12'h010, 1);
    check({31'd0, irq}, 1, "R7 irq follows mask");
    busRead(12'h018, 1, "R7 masked status set");

    busWrite(12'h01C, 1);
    check({31'd0, irq}, 0, "R8 irq drops on clear");
    busRead(12'h014, 0, "R8 no re-set while equal");

    busWrite(12'h004, 32'h900);
    busRead(12'h014, 0, "R6 compare write not equal");
    busWrite(12'h008, 32'h900);
    check({31'd0, irq}, 1, "R6 load write sets raw at once");
    busRead(12'h014, 1, "R6 raw after load match");

    busWrite(12'h01C, 1);
    busWrite(12'h008, 32'h1000);
    busWrite(12'h004, 32'h1001);
    busRead(12'h014, 0, "R5 raw clear before tick");
    repeat (H+2) @(negedge clk);
    busRead(12'h014, 1, "R5 tick sets raw");
    check({31'd0, irq}, 1, "R5 irq on tick match");

    busWrite(12'h01C, 32'hFFFF_FFFE);
    busRead(12'h014, 1, "R8 clear without bit0 keeps raw");

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule